// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one data character into one asynchronous serial frame on a single output line. The frame format comes from a set of line-control inputs: a data length of five to eight bits, an optional parity bit (odd, even, or a constant "stick" value), one or two stop bits, and a break control that pulls the line low. Bit timing comes from an external one-cycle `bit_tick` pulse at the bit rate, so each serial bit lasts exactly one tick interval. Characters arrive over a valid/ready handshake, and a `busy` flag stays high while any part of a frame is still being sent.

The control is a single state machine with the states `ST_IDLE`, `ST_SYNC`, `ST_START`, `ST_DATA`, `ST_PARITY`, `ST_STOP1` and `ST_STOP2`. A handshake in `ST_IDLE` captures the character and its format and moves to `ST_SYNC`. The remaining transitions happen only on `bit_tick`. `ST_SYNC` goes to `ST_START`, and `ST_START` goes to `ST_DATA`. `ST_DATA` stays put until the last data bit, then goes to `ST_PARITY` when parity is enabled or to `ST_STOP1` when it is not. `ST_PARITY` goes to `ST_STOP1`. `ST_STOP1` goes to `ST_STOP2` when two stop bits are selected, or back to `ST_IDLE`. `ST_STOP2` goes to `ST_IDLE`. `ST_SYNC` aligns the start bit with a tick boundary, so the start bit has the same length as every other bit.

Top module: `uart_frame_tx`

## Requirements
- R1: `tx_ready` is 1 only in the idle state, and a character is taken when `tx_valid` and `tx_ready` are both 1 at a clock edge. `busy` is 0 in idle and 1 from the edge after acceptance until the end of the last stop bit.
- R2: After acceptance the line stays 1 until the next `bit_tick`. Then a start bit of value 0 is sent for one tick interval.
- R3: The number of data bits is `cfg_wlen` + 5 (00 = 5, 01 = 6, 10 = 7, 11 = 8). Data bits go out least significant bit first. Bits of `tx_data` above that length are not sent.
- R4: With `cfg_par_en` = 1 and `cfg_stick` = 0, one parity bit follows the data bits. With `cfg_even` = 1 the data bits plus parity hold an even number of ones; with `cfg_even` = 0 they hold an odd number.
- R5: With `cfg_par_en` = 1 and `cfg_stick` = 1, the parity bit is 0 when `cfg_even` = 1 and 1 when `cfg_even` = 0. With `cfg_par_en` = 0, no parity bit is sent, whatever `cfg_stick` and `cfg_even` hold.
- R6: Stop bits have value 1. `cfg_two_stop` = 1 sends two stop bits and 0 sends one. `busy` falls only on a `bit_tick`.
- R7: While `cfg_break` = 1, `txd` is 0 in every state, idle included. When `cfg_break` returns to 0, the line shows the level the frame would otherwise have.
- R8: All format inputs except `cfg_break` are sampled at acceptance. Changing them during a frame has no effect on that frame.
- R9: The idle line is 1. A `tx_valid` presented while `busy` is 1 is not accepted and does not change the frame being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle pulse per serial bit period |
| tx_valid | input | 1 | Character offered |
| tx_ready | output | 1 | Block idle and able to take a character |
| tx_data | input | DATA_W | Character, least significant bit first on the line |
| cfg_wlen | input | WLEN_W | Data length minus 5 |
| cfg_par_en | input | 1 | Add a parity bit |
| cfg_even | input | 1 | Even parity if 1, odd if 0; sets the stick value |
| cfg_stick | input | 1 | Constant parity bit when parity is enabled |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cfg_break | input | 1 | Hold the line low (live, not sampled) |
| txd | output | 1 | Serial output |
| busy | output | 1 | Frame in progress |

## Verification
The bench sends frames for every data length, every parity mode and both stop settings, and checks every bit against a frame built in the bench by arithmetic. A design with the wrong length decode, or one that sends bits most significant first, fails the data-bit checks. A design that reverses the odd/even sense or the stick value fails the parity check. A design that leaves out the second stop bit or the `ST_SYNC` alignment shows a bit out of place. In every frame the bench changes the format inputs and offers a new character while the frame is being sent, so a design that reads the live format inputs, or takes a character while busy, produces a visibly wrong frame. Break is applied both in idle and in the middle of a data bit; a design that treats break as sampled fails to pull the line low, and one that lets break disturb the frame shows the wrong level once break is released.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2
    } tx_state_t;

    // Offset between the length field and the number of data bits
    localparam int unsigned WLEN_BIAS = 5;

endpackage

// File: rtl/uart_tx_parity.sv
module uart_tx_parity #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 4
) (
    input  logic [DATA_W-1:0] data,
    input  logic [CNT_W-1:0]  nbits,
    input  logic              even_sel,
    input  logic              stick,
    output logic              par_bit
);

    logic [DATA_W-1:0] keep;
    logic              ones_odd;

    // Keep only the bits that will actually be sent
    for (genvar i = 0; i < DATA_W; i++) begin : g_keep
        assign keep[i] = (CNT_W'(i) < nbits);
    end

    assign ones_odd = ^(data & keep);

    always_comb begin
        if (stick)
            par_bit = ~even_sel;
        else if (even_sel)
            par_bit = ones_odd;
        else
            par_bit = ~ones_odd;
    end

endmodule

// File: rtl/uart_tx_line.sv
module uart_tx_line
    import uart_tx_pkg::*;
(
    input  tx_state_t state,
    input  logic      data_bit,
    input  logic      par_bit,
    input  logic      brk,
    output logic      txd
);

    logic level;

    always_comb begin
        unique case (state)
            ST_IDLE:   level = 1'b1;
            ST_SYNC:   level = 1'b1;
            ST_START:  level = 1'b0;
            ST_DATA:   level = data_bit;
            ST_PARITY: level = par_bit;
            ST_STOP1:  level = 1'b1;
            ST_STOP2:  level = 1'b1;
            default:   level = 1'b1;
        endcase
    end

    assign txd = brk ? 1'b0 : level;

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_tx_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned WLEN_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [DATA_W-1:0] tx_data,
    input  logic [WLEN_W-1:0] cfg_wlen,
    input  logic              cfg_par_en,
    input  logic              cfg_even,
    input  logic              cfg_stick,
    input  logic              cfg_two_stop,
    input  logic              cfg_break,
    output logic              txd,
    output logic              busy
);

    localparam int unsigned CNT_W = $clog2(DATA_W + 1);

    tx_state_t         state_q, state_d;
    logic [DATA_W-1:0] shift_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  last_q;
    logic              par_en_q;
    logic              two_stop_q;
    logic              par_q;

    logic [CNT_W-1:0]  nbits_in;
    logic              par_in;
    logic              accept;

    assign nbits_in = CNT_W'(cfg_wlen) + CNT_W'(WLEN_BIAS);
    assign accept   = tx_valid && (state_q == ST_IDLE);

    uart_tx_parity #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_parity (
        .data     (tx_data),
        .nbits    (nbits_in),
        .even_sel (cfg_even),
        .stick    (cfg_stick),
        .par_bit  (par_in)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (tx_valid) state_d = ST_SYNC;
            ST_SYNC:   if (bit_tick) state_d = ST_START;
            ST_START:  if (bit_tick) state_d = ST_DATA;
            ST_DATA:   if (bit_tick && (cnt_q == last_q))
                           state_d = par_en_q ? ST_PARITY : ST_STOP1;
            ST_PARITY: if (bit_tick) state_d = ST_STOP1;
            ST_STOP1:  if (bit_tick) state_d = two_stop_q ? ST_STOP2 : ST_IDLE;
            ST_STOP2:  if (bit_tick) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Frame datapath: capture on accept, shift during data bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q    <= '0;
            cnt_q      <= '0;
            last_q     <= '0;
            par_en_q   <= 1'b0;
            two_stop_q <= 1'b0;
            par_q      <= 1'b0;
        end else if (accept) begin
            shift_q    <= tx_data;
            cnt_q      <= '0;
            last_q     <= nbits_in - CNT_W'(1);
            par_en_q   <= cfg_par_en;
            two_stop_q <= cfg_two_stop;
            par_q      <= par_in;
        end else if ((state_q == ST_DATA) && bit_tick) begin
            shift_q <= shift_q >> 1;
            cnt_q   <= cnt_q + CNT_W'(1);
        end
    end

    // Outputs
    always_comb begin
        tx_ready = (state_q == ST_IDLE);
        busy     = (state_q != ST_IDLE);
    end

    uart_tx_line u_line (
        .state    (state_q),
        .data_bit (shift_q[0]),
        .par_bit  (par_q),
        .brk      (cfg_break),
        .txd      (txd)
    );

endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic tx_valid,
    input logic tx_ready,
    input logic busy,
    input logic txd,
    input logic cfg_break
);

    assert_ready_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !tx_ready);

    assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> busy);

    assert_hold_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_tick) |=> busy);

    assert_end_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(bit_tick));

    assert_break_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_break |-> !txd);

    assert_idle_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cfg_break) |-> txd);

endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .busy      (busy),
    .txd       (txd),
    .cfg_break (cfg_break)
);

// File: tb/tb_uart_frame_tx.sv
`timescale 1ns/1ps
module tb_uart_frame_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [7:0] tx_data = '0;
    logic [1:0] cfg_wlen = '0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_even = 1'b0;
    logic       cfg_stick = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_break = 1'b0;
    logic       txd;
    logic       busy;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    uart_frame_tx dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_tick     (bit_tick),
        .tx_valid     (tx_valid),
        .tx_ready     (tx_ready),
        .tx_data      (tx_data),
        .cfg_wlen     (cfg_wlen),
        .cfg_par_en   (cfg_par_en),
        .cfg_even     (cfg_even),
        .cfg_stick    (cfg_stick),
        .cfg_two_stop (cfg_two_stop),
        .cfg_break    (cfg_break),
        .txd          (txd),
        .busy         (busy)
    );

    task automatic chk(input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", what, act, exp, $time);
        end
    endtask

    // Pulse bit_tick for one cycle, then wait one more cycle; ends on a negedge
    task automatic tick_bit();
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
        @(negedge clk);
    endtask

    // pm: 0 none (stick set, ignored), 1 odd, 2 even, 3 stick even_sel=1, 4 stick even_sel=0
    task automatic send_frame(input logic [7:0] d, input int wl, input int pm,
                              input bit two, input bit brk_probe);
        logic       exp_bits [0:11];
        logic [7:0] keep;
        int         nb;
        int         n;
        logic       pe, ev, st, ones, pbit;
        pe = (pm != 0);
        ev = (pm == 0) || (pm == 2) || (pm == 3);
        st = (pm == 0) || (pm >= 3);
        nb = wl + 5;
        keep = 8'((1 << nb) - 1);
        ones = ^(d & keep);
        if (st) pbit = ~ev; else if (ev) pbit = ones; else pbit = ~ones;
        n = 0;
        exp_bits[n] = 1'b0; n++;
        for (int i = 0; i < nb; i++) begin exp_bits[n] = d[i]; n++; end
        if (pe) begin exp_bits[n] = pbit; n++; end
        exp_bits[n] = 1'b1; n++;
        if (two) begin exp_bits[n] = 1'b1; n++; end

        @(negedge clk);
        cfg_wlen = 2'(wl); cfg_par_en = pe; cfg_even = ev; cfg_stick = st;
        cfg_two_stop = two; tx_data = d; tx_valid = 1'b1;
        chk(tx_ready, 1'b1, "R1 ready in idle");
        @(negedge clk);
        chk(busy, 1'b1, "R1 busy after accept");
        chk(tx_ready, 1'b0, "R1 ready low when busy");
        chk(txd, 1'b1, "R2 line high before first tick");
        // R8/R9: disturb format and offer another character mid-frame
        cfg_wlen = ~cfg_wlen; cfg_par_en = ~pe; cfg_even = ~ev; cfg_stick = ~st;
        cfg_two_stop = ~two; tx_data = ~d;
        for (int b = 0; b < n; b++) begin
            tick_bit();
            if (b == 0) chk(txd, exp_bits[b], "R2 start bit");
            else if (b <= nb) chk(txd, exp_bits[b], "R3 R8 data bit");
            else if (pe && b == nb + 1) chk(txd, exp_bits[b], "R4 R5 parity bit");
            else chk(txd, exp_bits[b], "R5 R6 stop bit");
            chk(busy, 1'b1, "R6 busy through frame");
            chk(tx_ready, 1'b0, "R9 no accept while busy");
            if (brk_probe && b == 2) begin
                cfg_break = 1'b1;
                @(negedge clk);
                chk(txd, 1'b0, "R7 break mid-frame");
                cfg_break = 1'b0;
                @(negedge clk);
                chk(txd, exp_bits[b], "R7 level after break release");
            end
        end
        tx_valid = 1'b0;
        tick_bit();
        chk(busy, 1'b0, "R6 busy low after last stop");
        chk(tx_ready, 1'b1, "R1 ready after frame");
        chk(txd, 1'b1, "R9 idle high");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_ready, 1'b1, "R1 reset ready");
        chk(busy, 1'b0, "R1 reset busy");
        chk(txd, 1'b1, "R9 reset line high");

        cfg_break = 1'b1;
        @(negedge clk);
        chk(txd, 1'b0, "R7 break in idle");
        cfg_break = 1'b0;
        @(negedge clk);
        chk(txd, 1'b1, "R7 idle after break");

        for (int wl = 0; wl < 4; wl++)
            for (int pm = 0; pm < 5; pm++)
                for (int two = 0; two < 2; two++)
                    for (int k = 0; k < 3; k++)
                        send_frame(8'h5A ^ 8'(k * 37 + wl * 11 + pm * 3), wl, pm,
                                   two[0], (k == 1));

        send_frame(8'hFF, 3, 2, 1'b0, 1'b0);
        send_frame(8'h00, 0, 1, 1'b1, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule